// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block performs the first of two address translation steps. A request carries a logical address split into a segment selector and an offset. The selector picks one entry of a small on-chip segment table. Each entry holds a base address, a length limit and a present flag. If the entry is present and the offset falls inside the limit, the block returns the linear address base + offset. That linear address is meant for a following paging stage. If the entry is absent or the offset is out of range, the block returns a fault code instead of an address.

Requests use a valid/ready handshake. The result sits in one output register, so a request accepted on one clock edge appears at the output after that edge. The downstream stage can hold off the output with its ready signal. While it does, the output is frozen and no new request is accepted. The table is loaded through a single write port. A write only affects requests accepted on later cycles. A request accepted on the same edge as a write still sees the old contents.

Top module: `seg_xlate`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every table entry is absent, so every lookup returns fault code 2'b01.
- R2: A request to a present entry with offset < limit returns out_code 2'b00 and out_addr = base + offset. It is valid at the output after the clock edge that accepted it.
- R3: An offset greater than or equal to the entry's limit returns out_code 2'b10 with out_addr 0. An offset of limit-1 passes. A limit of 0 faults on every offset.
- R4: A request to an absent entry returns out_code 2'b01 with out_addr 0, whatever its offset and limit.
- R5: A table write (wr_en high at an edge) affects requests accepted at later edges. A request accepted at the same edge uses the previous contents of the entry.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_addr and out_code hold their values and in_ready is 0.
- R7: in_ready is 1 whenever the output register is empty or is being drained in the same cycle, which gives one accepted request per cycle under full flow.
- R8: The sum base + offset wraps modulo 2^32.
- R9: A write changes only the entry selected by wr_idx. All other entries keep their base, limit and present flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_seg | input | 3 | Segment selector |
| in_off | input | 20 | Offset within the segment |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 32 | Linear address, 0 on a fault |
| out_code | output | 2 | 00 ok, 01 absent entry, 10 offset out of range |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 32 | New base |
| wr_limit | input | 20 | New limit (segment length) |
| wr_valid | input | 1 | New present flag |

## Verification
The bench targets the limit boundary: an offset of limit-1, an offset equal to the limit, and a zero limit. A design using `<=` in place of `<` would accept exactly one byte past each segment. It also targets a write and a request to the same entry on the same edge. A design that forwarded the write data would translate that request when it should fault. Bases near the top of the address space check wrap-around, so a truncated or saturating adder would return wrong addresses. Random back-pressure checks that a stalled result stays frozen. A block that overwrote its output register while stalled would lose or duplicate results, and the in-order scoreboard would flag it.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_BOUND  = 2'b10
  } flt_e;
endpackage

// File: rtl/seg_rst_sync.sv
`timescale 1ns/1ps
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/seg_table.sv
`timescale 1ns/1ps
module seg_table #(
  parameter int NUM_SEG = 8,
  parameter int BASE_W  = 32,
  parameter int LIM_W   = 20,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic              rd_valid
);
  logic [BASE_W-1:0] base_q [NUM_SEG];
  logic [LIM_W-1:0]  lim_q  [NUM_SEG];
  logic [NUM_SEG-1:0] valid_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    logic              ld_en;
    logic [BASE_W-1:0] base_d;
    logic [LIM_W-1:0]  lim_d;
    logic              valid_d;

    always_comb begin
      ld_en   = wr_en && (wr_idx == IDX_W'(g));
      base_d  = ld_en ? wr_base  : base_q[g];
      lim_d   = ld_en ? wr_limit : lim_q[g];
      valid_d = ld_en ? wr_valid : valid_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        lim_q[g]   <= '0;
        valid_q[g] <= 1'b0;
      end else begin
        base_q[g]  <= base_d;
        lim_q[g]   <= lim_d;
        valid_q[g] <= valid_d;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = lim_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  // R9: present flags only move on a write
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q));
  // R5: a write is visible from the following cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)));
endmodule

// File: rtl/seg_check.sv
`timescale 1ns/1ps
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int LIM_W  = 20
) (
  input  logic              ent_valid,
  input  logic [BASE_W-1:0] ent_base,
  input  logic [LIM_W-1:0]  ent_limit,
  input  logic [LIM_W-1:0]  off,
  output logic [BASE_W-1:0] lin_addr,
  output flt_e              code
);
  logic              in_range;
  logic [BASE_W-1:0] sum;

  always_comb begin
    in_range = off < ent_limit;
    sum      = ent_base + BASE_W'(off);
    if (!ent_valid) begin
      code     = FLT_ABSENT;
      lin_addr = '0;
    end else if (!in_range) begin
      code     = FLT_BOUND;
      lin_addr = '0;
    end else begin
      code     = FLT_NONE;
      lin_addr = sum;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int BASE_W  = 32,
  parameter int LIM_W   = 20,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_seg,
  input  logic [LIM_W-1:0]  in_off,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BASE_W-1:0] out_addr,
  output logic [1:0]        out_code,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_valid
);
  logic              rst_n;
  logic [BASE_W-1:0] tbl_base;
  logic [LIM_W-1:0]  tbl_limit;
  logic              tbl_valid;
  logic [BASE_W-1:0] chk_addr;
  flt_e              chk_code;

  logic              accept;
  logic              res_valid_q, res_valid_d;
  logic [BASE_W-1:0] res_addr_q,  res_addr_d;
  flt_e              res_code_q,  res_code_d;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  seg_table #(.NUM_SEG(NUM_SEG), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_base  (wr_base),
    .wr_limit (wr_limit),
    .wr_valid (wr_valid),
    .rd_idx   (in_seg),
    .rd_base  (tbl_base),
    .rd_limit (tbl_limit),
    .rd_valid (tbl_valid)
  );

  seg_check #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_chk (
    .ent_valid (tbl_valid),
    .ent_base  (tbl_base),
    .ent_limit (tbl_limit),
    .off       (in_off),
    .lin_addr  (chk_addr),
    .code      (chk_code)
  );

  assign in_ready = !res_valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    res_valid_d = res_valid_q;
    res_addr_d  = res_addr_q;
    res_code_d  = res_code_q;
    if (accept) begin
      res_valid_d = 1'b1;
      res_addr_d  = chk_addr;
      res_code_d  = chk_code;
    end else if (out_ready) begin
      res_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_addr_q  <= '0;
      res_code_q  <= FLT_NONE;
    end else begin
      res_valid_q <= res_valid_d;
      res_addr_q  <= res_addr_d;
      res_code_q  <= res_code_d;
    end
  end

  assign out_valid = res_valid_q;
  assign out_addr  = res_addr_q;
  assign out_code  = res_code_q;

  // R7: an accepted request fills the output register
  a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R6: a stalled result is frozen
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_code)));
  // R3: a fault carries no address
  a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code != 2'b00) |-> (out_addr == '0));
  // R4: an absent entry yields the absent code
  a_r4_absent_code: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tbl_valid) |=> (out_code == 2'b01));
endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  in_seg, wr_idx;
  logic [19:0] in_off, wr_limit;
  logic [31:0] out_addr, wr_base;
  logic [1:0]  out_code;
  logic        wr_en, wr_valid;

  always #4 clk = ~clk;

  seg_xlate uut (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_seg(in_seg), .in_off(in_off), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_code(out_code), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_valid(wr_valid)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  code;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] m_base [8];
  logic [19:0] m_lim  [8];
  logic        m_val  [8];
  int          n_chk = 0;
  int          n_bad = 0;
  string       tag_ovr = "";
  logic        held = 1'b0;
  logic [31:0] held_addr;
  logic [1:0]  held_code;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [2:0] s, input logic [19:0] off);
    exp_t e;
    logic [32:0] full;
    e.addr = '0;
    if (!m_val[s]) begin
      e.code = 2'b01; e.tag = "R4";
    end else if (off >= m_lim[s]) begin
      e.code = 2'b10; e.tag = "R3";
    end else begin
      full   = {1'b0, m_base[s]} + {13'b0, off};
      e.addr = full[31:0];
      e.code = 2'b00;
      e.tag  = full[32] ? "R8" : "R2";
    end
    if (tag_ovr != "") e.tag = tag_ovr;
    return e;
  endfunction

  // Called just after a falling edge with all inputs driven.
  task automatic step();
    bit   acc, drain, stall;
    exp_t e;
    #1;
    if (held) begin
      check(out_valid && out_addr == held_addr && out_code == held_code, "R6",
            "stalled output moved", out_addr, held_addr);
      held = 1'b0;
    end
    acc   = in_valid && in_ready;
    drain = out_valid && out_ready;
    stall = out_valid && !out_ready;
    if (out_valid) check(in_ready == out_ready, out_ready ? "R7" : "R6",
                         "in_ready", {31'b0, in_ready}, {31'b0, out_ready});
    if (drain) begin
      if (q.size() == 0) check(1'b0, "R7", "unexpected result", out_addr, 32'h0);
      else begin
        e = q.pop_front();
        check(out_code == e.code && out_addr == e.addr, e.tag, "result",
              {out_code, out_addr[29:0]}, {e.code, e.addr[29:0]});
        if (out_addr != e.addr) check(1'b0, e.tag, "address", out_addr, e.addr);
      end
    end
    if (acc) q.push_back(predict(in_seg, in_off));
    if (stall) begin
      held = 1'b1; held_addr = out_addr; held_code = out_code;
    end
    if (wr_en) begin
      m_base[wr_idx] = wr_base; m_lim[wr_idx] = wr_limit; m_val[wr_idx] = wr_valid;
    end
    @(posedge clk);
    @(negedge clk);
    check(out_valid == (acc || stall), "R7", "out_valid", {31'b0, out_valid},
          {31'b0, (acc || stall)});
  endtask

  task automatic drive(input bit v, input logic [2:0] s, input logic [19:0] off,
                       input bit rdy);
    in_valid = v; in_seg = s; in_off = off; out_ready = rdy; wr_en = 1'b0;
    step();
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] b, input logic [19:0] l,
                    input bit v);
    wr_en = 1'b1; wr_idx = i; wr_base = b; wr_limit = l; wr_valid = v;
    in_valid = 1'b0; out_ready = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_val[i] = 1'b0;
    end
    arst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_seg = '0; in_off = '0;
    wr_en = 1'b0; wr_idx = '0; wr_base = '0; wr_limit = '0; wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!out_valid, "R1", "out_valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready, "R1", "in_ready after reset", {31'b0, in_ready}, 32'h1);
    tag_ovr = "R1";
    for (int i = 0; i < 8; i++) drive(1'b1, 3'(i), 20'(i * 7), 1'b1);
    tag_ovr = "";
    drive(1'b0, 3'd0, 20'd0, 1'b1);

    // R3 / R2 boundary around the limit
    wr(3'd3, 32'h1000_0000, 20'h100, 1'b1);
    drive(1'b1, 3'd3, 20'h0FF, 1'b1);
    drive(1'b1, 3'd3, 20'h100, 1'b1);
    drive(1'b1, 3'd3, 20'hFFFFF, 1'b1);
    wr(3'd5, 32'h2000_0000, 20'h0, 1'b1);
    drive(1'b1, 3'd5, 20'h0, 1'b1);
    // R8 wrap-around
    wr(3'd6, 32'hFFFF_FF00, 20'hFFFFF, 1'b1);
    drive(1'b1, 3'd6, 20'h200, 1'b1);
    // R4 absent entry with large limit
    wr(3'd7, 32'h3000_0000, 20'hFFFFF, 1'b0);
    drive(1'b1, 3'd7, 20'h1, 1'b1);
    // R5 write and request on the same edge
    tag_ovr = "R5";
    in_valid = 1'b1; in_seg = 3'd2; in_off = 20'h10; out_ready = 1'b1;
    wr_en = 1'b1; wr_idx = 3'd2; wr_base = 32'h4000_0000; wr_limit = 20'h80; wr_valid = 1'b1;
    step();
    wr_en = 1'b0;
    drive(1'b1, 3'd2, 20'h10, 1'b1);
    // R9 neighbours untouched by a write
    tag_ovr = "R9";
    wr(3'd4, 32'h5000_0000, 20'h40, 1'b1);
    drive(1'b1, 3'd3, 20'h0FF, 1'b1);
    drive(1'b1, 3'd5, 20'h0, 1'b1);
    tag_ovr = "";
    // R6 explicit stall
    drive(1'b1, 3'd4, 20'h3F, 1'b0);
    drive(1'b1, 3'd4, 20'h01, 1'b0);
    drive(1'b1, 3'd4, 20'h01, 1'b1);
    drive(1'b0, 3'd0, 20'h0, 1'b1);

    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      in_valid  = ($urandom % 10) < 7;
      in_seg    = 3'($urandom);
      in_off    = ($urandom % 4) == 0 ? 20'($urandom) : 20'($urandom % 20'h500);
      out_ready = ($urandom % 10) < 7;
      wr_en     = ($urandom % 10) == 0;
      wr_idx    = 3'($urandom);
      wr_base   = ($urandom % 4) == 0 ? (32'hFFFF_0000 | 32'($urandom % 32'h10000)) : $urandom;
      wr_limit  = ($urandom % 8) == 0 ? 20'h0 : 20'($urandom % 20'h400);
      wr_valid  = ($urandom % 5) != 0;
      step();
    end
    wr_en = 1'b0;
    for (int c = 0; c < 8 && (out_valid || q.size() != 0); c++) drive(1'b0, 3'd0, 20'h0, 1'b1);
    check(q.size() == 0, "R7", "results outstanding", 32'(q.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule